// File: doc/BRIEF.md
# Float-to-Integer Converter

This unit turns a binary32 or binary64 floating-point operand into a signed 32-bit or 64-bit integer. A pulse on `start` captures every input. After two clock edges the unit pulses `done` and presents the new 64-bit destination register value, a 2-bit condition code, and the inexact and invalid flags. The outputs hold their values until the next conversion completes.

The rounding mode is chosen for each operation by a 3-bit modifier. Some modifier values point back to the current mode input. When the integer is 32 bits wide, only the low word of the destination changes. The upper word is copied from the old destination value given with the operation.

Top module: `fcvt_to_int`

## Requirements
- R1: `done` is high for exactly the one cycle that follows the second rising edge after a cycle with `start` high. All inputs are sampled in the `start` cycle.
- R2: Modifier values 0, 2 and 3 use `cur_mode`. That input is encoded as 0 = nearest-even, 1 = toward zero, 2 = toward +inf, 3 = toward -inf.
- R3: Modifier values 1 and 4 round to nearest, with ties going to the even integer (2.5→2, 1.5→2, -2.5→-2).
- R4: Modifier 5 truncates toward zero, 6 rounds toward +inf and 7 rounds toward -inf.
- R5: When `dst_is_64`=0, `result[31:0]` holds the 32-bit integer and `result[63:32]` equals `old_dst[63:32]`. When `dst_is_64`=1, all 64 bits are the integer.
- R6: `cc` depends only on the source. It is 3 for NaN, 0 for ±0, 1 for any other negative value (including -inf) and 2 for any other positive value.
- R7: A NaN source gives the most negative integer of the target width. An infinity or a rounded value that does not fit gives the most negative integer if the source is negative and the most positive integer if it is positive. In each of these cases `invalid`=1.
- R8: `inexact`=1 exactly when discarded fraction bits are nonzero and `invalid`=0.
- R9: `src_is_dbl`=0 reads `src[31:0]` as binary32. `src_is_dbl`=1 reads all 64 bits as binary64.
- R10: After reset, `done`, `result`, `cc`, `inexact` and `invalid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion; inputs are sampled in this cycle |
| src | input | 64 | Source operand bits |
| src_is_dbl | input | 1 | 1 = binary64 source, 0 = binary32 in bits 31:0 |
| dst_is_64 | input | 1 | 1 = 64-bit integer, 0 = 32-bit integer merged into the low word |
| rnd_mod | input | 3 | Per-operation rounding modifier |
| cur_mode | input | 2 | Current rounding mode |
| old_dst | input | 64 | Previous destination register value |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | New destination register value |
| cc | output | 2 | Condition code derived from the source |
| inexact | output | 1 | Fraction was discarded |
| invalid | output | 1 | NaN, infinity or out-of-range source |

## Verification
Positive and negative halfway cases such as ±2.5 and 1.5 separate ties-to-even from the directed modes. Values like ±2.25 and 2.75 separate the three directed modes from each other and from truncation, and they are sent once through explicit modifiers and once through `cur_mode`. Sources at exactly ±2^31 and ±2^63 distinguish the asymmetric integer limits. A sub-unit value, NaN, infinity and signed zero exercise the guard and sticky path, saturation and the condition code. A binary32 source that is valid as a 64-bit integer but overflows 32 bits shows that both the format decode and the width-dependent limit are applied.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int SIG_W  = 53;
  localparam int EXP_W  = 13;
  localparam int INT_W  = 64;
  localparam int HALF_W = INT_W / 2;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_inf;
    logic             is_zero;
    logic [EXP_W-1:0] exp;   // unbiased, two's complement
    logic [SIG_W-1:0] sig;   // hidden bit at the top
  } unpacked_t;

  function automatic rmode_e pick_mode(logic [2:0] m, rmode_e cur);
    case (m)
      3'd1, 3'd4: return RM_NEAR;
      3'd5:       return RM_ZERO;
      3'd6:       return RM_UP;
      3'd7:       return RM_DOWN;
      default:    return cur;
    endcase
  endfunction

  function automatic logic round_up(rmode_e m, logic sign, logic lsb,
                                    logic g, logic s);
    case (m)
      RM_NEAR: return g & (s | lsb);
      RM_UP:   return (g | s) & ~sign;
      RM_DOWN: return (g | s) & sign;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] class_cc(unpacked_t u);
    if (u.is_nan)       return 2'd3;
    else if (u.is_zero) return 2'd0;
    else if (u.sign)    return 2'd1;
    else                return 2'd2;
  endfunction
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [63:0] bits,
  input  logic        is_dbl,
  output unpacked_t   u
);
  logic [7:0]  e_s;
  logic [22:0] f_s;
  logic [10:0] e_d;
  logic [51:0] f_d;

  always_comb begin
    e_s = bits[30:23];
    f_s = bits[22:0];
    e_d = bits[62:52];
    f_d = bits[51:0];
    u   = '0;
    if (is_dbl) begin
      u.sign    = bits[63];
      u.is_nan  = (e_d == 11'h7FF) && (f_d != '0);
      u.is_inf  = (e_d == 11'h7FF) && (f_d == '0);
      u.is_zero = (e_d == '0) && (f_d == '0);
      u.exp     = (e_d == '0) ? -13'sd1022 : ({2'b0, e_d} - 13'd1023);
      u.sig     = {e_d != '0, f_d};
    end else begin
      u.sign    = bits[31];
      u.is_nan  = (e_s == 8'hFF) && (f_s != '0);
      u.is_inf  = (e_s == 8'hFF) && (f_s == '0);
      u.is_zero = (e_s == '0) && (f_s == '0);
      u.exp     = (e_s == '0) ? -13'sd126 : ({5'b0, e_s} - 13'd127);
      u.sig     = {e_s != '0, f_s, 29'b0};
    end
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  unpacked_t   u,
  input  rmode_e      mode,
  input  logic        to64,
  output logic [63:0] ival,
  output logic        ovf_evt,
  output logic        frac_evt,
  output logic        inexact,
  output logic        invalid
);
  logic [127:0] t;
  logic [6:0]   sh;
  logic [63:0]  ipart;
  logic         g, s, inc, big, tiny;
  logic [64:0]  mag, limit;
  logic signed [EXP_W-1:0] e;

  always_comb begin
    e     = $signed(u.exp);
    big   = u.is_inf || (e > 13'sd63);
    tiny  = e < -13'sd1;
    sh    = 7'(u.exp + 13'd1);
    t     = {64'b0, u.sig, 11'b0} << sh;
    if (tiny) begin
      ipart = '0;
      g     = 1'b0;
      s     = |u.sig;
    end else begin
      ipart = t[127:64];
      g     = t[63];
      s     = |t[62:0];
    end
    inc      = round_up(mode, u.sign, ipart[0], g, s);
    mag      = {1'b0, ipart} + {64'b0, inc};
    limit    = to64 ? (65'd1 << 63) : (65'd1 << 31);
    ovf_evt  = !u.is_nan && (big || (u.sign ? (mag > limit) : (mag >= limit)));
    frac_evt = !big && (g | s);
    invalid  = u.is_nan | ovf_evt;
    inexact  = frac_evt & ~invalid;
    if (u.is_nan || (ovf_evt && u.sign))
      ival = to64 ? 64'h8000_0000_0000_0000 : 64'hFFFF_FFFF_8000_0000;
    else if (ovf_evt)
      ival = to64 ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    else
      ival = u.sign ? (64'd0 - mag[63:0]) : mag[63:0];
  end
endmodule

// File: rtl/fcvt_to_int.sv
module fcvt_to_int
  import fcvt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] src,
  input  logic        src_is_dbl,
  input  logic        dst_is_64,
  input  logic [2:0]  rnd_mod,
  input  logic [1:0]  cur_mode,
  input  logic [63:0] old_dst,
  output logic        done,
  output logic [63:0] result,
  output logic [1:0]  cc,
  output logic        inexact,
  output logic        invalid
);
  logic        busy_q, dbl_q, w64_q;
  logic [63:0] src_q, old_q;
  rmode_e      mode_q;

  unpacked_t   u;
  logic [63:0] ival;
  logic        ovf_evt, frac_evt, ix_w, iv_w;
  logic [63:0] merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dbl_q  <= 1'b0;
      w64_q  <= 1'b0;
      src_q  <= '0;
      old_q  <= '0;
      mode_q <= RM_NEAR;
    end else begin
      busy_q <= start;
      if (start) begin
        dbl_q  <= src_is_dbl;
        w64_q  <= dst_is_64;
        src_q  <= src;
        old_q  <= old_dst;
        mode_q <= pick_mode(rnd_mod, rmode_e'(cur_mode));
      end
    end
  end

  fcvt_unpack u_unpack (.bits(src_q), .is_dbl(dbl_q), .u(u));

  fcvt_round u_round (
    .u(u), .mode(mode_q), .to64(w64_q), .ival(ival),
    .ovf_evt(ovf_evt), .frac_evt(frac_evt),
    .inexact(ix_w), .invalid(iv_w)
  );

  assign merged = w64_q ? ival : {old_q[63:32], ival[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      result  <= '0;
      cc      <= 2'd0;
      inexact <= 1'b0;
      invalid <= 1'b0;
    end else begin
      done <= busy_q;
      if (busy_q) begin
        result  <= merged;
        cc      <= class_cc(u);
        inexact <= ix_w;
        invalid <= iv_w;
      end
    end
  end
endmodule

// File: rtl/fcvt_to_int_chk.sv
module fcvt_to_int_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        dst_is_64,
  input logic [63:0] old_dst,
  input logic        done,
  input logic [63:0] result,
  input logic [1:0]  cc,
  input logic        inexact,
  input logic        invalid,
  input logic        ovf_evt
);
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done); // R1
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(start, 2)); // R1
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !$past(dst_is_64, 2)) |-> result[63:32] == $past(old_dst[63:32], 2)); // R5
  AST_NAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd3) |-> invalid); // R7
  AST_POS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && invalid && cc == 2'd2 && $past(dst_is_64, 2))
      |-> result == 64'h7FFF_FFFF_FFFF_FFFF); // R7
  AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cc == 2'd0) |-> (!inexact && !invalid && result[31:0] == 32'd0)); // R6
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(inexact && invalid)); // R8
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> invalid); // R7
endmodule

bind fcvt_to_int fcvt_to_int_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dst_is_64(dst_is_64),
  .old_dst(old_dst), .done(done), .result(result), .cc(cc),
  .inexact(inexact), .invalid(invalid), .ovf_evt(ovf_evt)
);

// File: tb/fcvt_to_int_bench.sv
module fcvt_to_int_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] src = '0;
  logic        src_is_dbl = 1'b0;
  logic        dst_is_64 = 1'b0;
  logic [2:0]  rnd_mod = '0;
  logic [1:0]  cur_mode = '0;
  logic [63:0] old_dst = '0;
  logic        done, inexact, invalid;
  logic [63:0] result;
  logic [1:0]  cc;
  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcvt_to_int u_fcvt_to_int (
    .clk(clk), .rst_n(rst_n), .start(start), .src(src),
    .src_is_dbl(src_is_dbl), .dst_is_64(dst_is_64), .rnd_mod(rnd_mod),
    .cur_mode(cur_mode), .old_dst(old_dst), .done(done), .result(result),
    .cc(cc), .inexact(inexact), .invalid(invalid)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic conv(string tag, logic [63:0] s, bit dbl, bit w64,
                      logic [2:0] m, logic [1:0] cur, logic [63:0] old,
                      logic [63:0] e_res, logic [1:0] e_cc, bit e_ix, bit e_iv);
    src = s; src_is_dbl = dbl; dst_is_64 = w64; rnd_mod = m;
    cur_mode = cur; old_dst = old; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    src = '1; old_dst = '0; rnd_mod = 3'd7; cur_mode = 2'd3;
    @(negedge clk);
    chk({tag, " R1 done"}, {63'b0, done}, 64'd1);
    chk({tag, " result"}, result, e_res);
    chk({tag, " R6 cc"}, {62'b0, cc}, {62'b0, e_cc});
    chk({tag, " R8 inexact"}, {63'b0, inexact}, {63'b0, e_ix});
    chk({tag, " R7 invalid"}, {63'b0, invalid}, {63'b0, e_iv});
    @(negedge clk);
    chk({tag, " R1 done pulse"}, {63'b0, done}, 64'd0);
  endtask

  localparam logic [63:0] OLD = 64'hDEAD_BEEF_1234_5678;
  localparam logic [63:0] NEG2 = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [63:0] NEG3 = 64'hFFFF_FFFF_FFFF_FFFD;

  task automatic t_reset();
    chk("R10 done", {63'b0, done}, 64'd0);
    chk("R10 result", result, 64'd0);
    chk("R10 flags", {60'b0, cc, inexact, invalid}, 64'd0);
  endtask

  task automatic t_nearest();
    conv("R3 2.5", 64'h4004_0000_0000_0000, 1, 1, 3'd1, 2'd1, OLD, 64'd2, 2, 1, 0);
    conv("R3 1.5", 64'h3FF8_0000_0000_0000, 1, 1, 3'd4, 2'd1, OLD, 64'd2, 2, 1, 0);
    conv("R3 -2.5", 64'hC004_0000_0000_0000, 1, 1, 3'd4, 2'd2, OLD, NEG2, 1, 1, 0);
  endtask

  task automatic t_directed();
    conv("R4 rz 2.75", 64'h4006_0000_0000_0000, 1, 1, 3'd5, 2'd0, OLD, 64'd2, 2, 1, 0);
    conv("R4 rz -2.75", 64'hC006_0000_0000_0000, 1, 1, 3'd5, 2'd0, OLD, NEG2, 1, 1, 0);
    conv("R4 up 2.25", 64'h4002_0000_0000_0000, 1, 1, 3'd6, 2'd0, OLD, 64'd3, 2, 1, 0);
    conv("R4 up -2.25", 64'hC002_0000_0000_0000, 1, 1, 3'd6, 2'd0, OLD, NEG2, 1, 1, 0);
    conv("R4 dn 2.25", 64'h4002_0000_0000_0000, 1, 1, 3'd7, 2'd0, OLD, 64'd2, 2, 1, 0);
    conv("R4 dn -2.25", 64'hC002_0000_0000_0000, 1, 1, 3'd7, 2'd0, OLD, NEG3, 1, 1, 0);
    conv("R8 up 0.25", 64'h3FD0_0000_0000_0000, 1, 1, 3'd6, 2'd0, OLD, 64'd1, 2, 1, 0);
    conv("R8 rne 0.25", 64'h3FD0_0000_0000_0000, 1, 1, 3'd1, 2'd0, OLD, 64'd0, 2, 1, 0);
  endtask

  task automatic t_current();
    conv("R2 m0 rz", 64'h4006_0000_0000_0000, 1, 1, 3'd0, 2'd1, OLD, 64'd2, 2, 1, 0);
    conv("R2 m2 up", 64'h4002_0000_0000_0000, 1, 1, 3'd2, 2'd2, OLD, 64'd3, 2, 1, 0);
    conv("R2 m3 dn", 64'hC002_0000_0000_0000, 1, 1, 3'd3, 2'd3, OLD, NEG3, 1, 1, 0);
    conv("R2 m0 rne", 64'h4004_0000_0000_0000, 1, 1, 3'd0, 2'd0, OLD, 64'd2, 2, 1, 0);
  endtask

  task automatic t_merge();
    conv("R5 2.5 narrow", 64'h4004_0000_0000_0000, 1, 0, 3'd4, 2'd0, OLD,
         64'hDEAD_BEEF_0000_0002, 2, 1, 0);
    conv("R5 -2.5 narrow", 64'hC004_0000_0000_0000, 1, 0, 3'd4, 2'd0, OLD,
         64'hDEAD_BEEF_FFFF_FFFE, 1, 1, 0);
    conv("R5 exact 3", 64'h4008_0000_0000_0000, 1, 0, 3'd5, 2'd0, 64'h0123_4567_89AB_CDEF,
         64'h0123_4567_0000_0003, 2, 0, 0);
  endtask

  task automatic t_limits();
    conv("R7 +2^63", 64'h43E0_0000_0000_0000, 1, 1, 3'd5, 2'd0, OLD,
         64'h7FFF_FFFF_FFFF_FFFF, 2, 0, 1);
    conv("R7 -2^63", 64'hC3E0_0000_0000_0000, 1, 1, 3'd5, 2'd0, OLD,
         64'h8000_0000_0000_0000, 1, 0, 0);
    conv("R7 +2^31 narrow", 64'h41E0_0000_0000_0000, 1, 0, 3'd5, 2'd0, OLD,
         64'hDEAD_BEEF_7FFF_FFFF, 2, 0, 1);
    conv("R7 -2^31 narrow", 64'hC1E0_0000_0000_0000, 1, 0, 3'd5, 2'd0, OLD,
         64'hDEAD_BEEF_8000_0000, 1, 0, 0);
    conv("R7 nan", 64'h7FF8_0000_0000_0000, 1, 1, 3'd4, 2'd0, OLD,
         64'h8000_0000_0000_0000, 3, 0, 1);
    conv("R7 nan narrow", 64'h7FF8_0000_0000_0001, 1, 0, 3'd4, 2'd0, OLD,
         64'hDEAD_BEEF_8000_0000, 3, 0, 1);
    conv("R7 +inf", 64'h7FF0_0000_0000_0000, 1, 1, 3'd4, 2'd0, OLD,
         64'h7FFF_FFFF_FFFF_FFFF, 2, 0, 1);
    conv("R7 -inf", 64'hFFF0_0000_0000_0000, 1, 1, 3'd4, 2'd0, OLD,
         64'h8000_0000_0000_0000, 1, 0, 1);
  endtask

  task automatic t_zero_single();
    conv("R6 +0", 64'h0, 1, 1, 3'd6, 2'd0, OLD, 64'd0, 0, 0, 0);
    conv("R6 -0", 64'h8000_0000_0000_0000, 1, 1, 3'd7, 2'd0, OLD, 64'd0, 0, 0, 0);
    conv("R9 f32 2.5", 64'hFFFF_FFFF_4020_0000, 0, 1, 3'd1, 2'd0, OLD, 64'd2, 2, 1, 0);
    conv("R9 f32 -1.5", 64'h0000_0000_BFC0_0000, 0, 1, 3'd7, 2'd0, OLD, NEG2, 1, 1, 0);
    conv("R9 f32 2^40", 64'h0000_0000_5380_0000, 0, 1, 3'd5, 2'd0, OLD,
         64'h0000_0100_0000_0000, 2, 0, 0);
    conv("R9 f32 2^40 narrow", 64'h0000_0000_5380_0000, 0, 0, 3'd5, 2'd0, OLD,
         64'hDEAD_BEEF_7FFF_FFFF, 2, 0, 1);
    conv("R9 f32 nan", 64'h0000_0000_7FC0_0000, 0, 1, 3'd5, 2'd0, OLD,
         64'h8000_0000_0000_0000, 3, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_nearest();
    t_directed();
    t_current();
    t_merge();
    t_limits();
    t_zero_single();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule